// File: doc/BRIEF.md
# Machine-Mode Trap Controller

This block decides, for one hart, when a trap is taken and where execution goes next. Each cycle it looks at a synchronous exception request, three interrupt request lines (software, timer, external) and two return strobes, one for returning from machine mode and one for returning from supervisor mode. From these it produces a redirect strobe and target PC, and it tracks the hart's privilege level. It holds the trap-related state for machine mode and for one delegated supervisor mode: vector bases, delegation masks, saved PCs, causes, trap values and a one-deep stack of interrupt enable and previous privilege.

A trap goes to machine mode unless its cause bit is set in the matching delegation mask. In that case, and only if the hart is not already in machine mode, it goes to supervisor mode. Interrupts may be vectored per cause. Exceptions always enter at the vector base. A small register port lets software program and inspect the state. A hardware trap or return in the same cycle wins over a write on that port.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the privilege is machine (privMode encodings: user 0, supervisor 1, machine 3), the status word reads 0, all cause registers read 0 and redirectValid is low.
- R2: A non-delegated exception raises redirectValid in the same cycle, with redirectPc equal to the machine vector with its two low bits cleared. On the next edge it stores curPc in the machine exception PC, {0, code} in the machine cause and excTval in the machine trap value, and the privilege becomes machine.
- R3: On trap entry the target mode's previous-enable bit takes its enable bit, the enable bit is cleared and the previous-privilege field takes the prior privilege. Status bits: sie 1, mie 3, spie 5, mpie 7, spp 8, mpp 12:11.
- R4: A machine return redirects to the machine exception PC, restores privilege from mpp, copies mpie into mie, sets mpie and clears mpp to user. A supervisor return does the same with sepc, spp, spie and sie.
- R5: When a vector register's low two bits are 01, an interrupt redirects to base + 4*code. An exception always goes to base. Low bits 00 select base for every trap.
- R6: When the cause bit is set in the exception delegation mask (exceptions) or the interrupt delegation mask (interrupts) and the privilege is not machine, the trap uses the supervisor vector, cause, exception PC and trap value, and the privilege becomes supervisor. Machine state is left unchanged.
- R7: A trap taken in machine mode always stays in machine mode, whatever the delegation masks hold, and no trap ever lowers the privilege.
- R8: An interrupt is taken only if its enable bit is set (software bit 3, timer bit 7, external bit 11) and its target mode allows it. The target allows it when it is above the current privilege. When the target equals the current privilege, the target's global enable must also be set.
- R9: Interrupt codes are software 3, timer 7, external 11. Priority is external, then software, then timer. An interrupt cause has bit XLEN-1 set, and the trap value written is 0.
- R10: An exception in the same cycle as a takeable interrupt is taken instead of the interrupt.
- R11: When excEcall is set, the cause code is 8 from user, 9 from supervisor and 11 from machine, and excCode is ignored.
- R12: The register port maps address 0 status, 1 interrupt enable, 2 machine vector, 3 exception delegation, 4 interrupt delegation, 5 machine exception PC, 6 machine cause, 7 machine trap value, 8 supervisor vector, 9 supervisor exception PC, 10 supervisor cause and 11 supervisor trap value. Unmapped addresses read 0, and a write takes effect only when no trap or return occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excValid | input | 1 | Synchronous exception request this cycle |
| excEcall | input | 1 | The exception is an environment call (code derived from privilege) |
| excCode | input | 4 | Exception cause code |
| excTval | input | XLEN | Exception trap value |
| curPc | input | XLEN | PC of the instruction at the trap point |
| irqSoft | input | 1 | Software interrupt pending |
| irqTimer | input | 1 | Timer interrupt pending |
| irqExt | input | 1 | External interrupt pending |
| mretValid | input | 1 | Return from machine trap |
| sretValid | input | 1 | Return from supervisor trap |
| csrWe | input | 1 | Register port write enable |
| csrAddr | input | 4 | Register port address |
| csrWdata | input | XLEN | Register port write data |
| csrRdata | output | XLEN | Register port read data |
| redirectValid | output | 1 | Fetch must redirect this cycle |
| redirectPc | output | XLEN | Redirect target |
| privMode | output | 2 | Current privilege level |

## Verification
The hardest case to reach is a trap that goes to machine mode while the hart sits in delegated supervisor mode. Reaching it first requires an environment call from user mode that the delegation mask routes to supervisor. Only then can an undelegated external interrupt be raised, and a delegated timer interrupt raised alongside it must stay masked by the cleared supervisor enable. The stimulus then unwinds both stack levels with a machine return followed by a supervisor return. The bench checks that the return targets, the privilege levels and the saved previous-privilege fields line up with the order of entry.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int CAUSE_W = 4;
  localparam int NUM_CODES = 1 << CAUSE_W;
  localparam int CSR_AW = 4;
  localparam int NUM_IRQ = 3;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // interrupt sources in priority order: external, software, timer
  localparam logic [CAUSE_W-1:0] IRQ_CODE [NUM_IRQ] = '{4'd11, 4'd3, 4'd7};
  localparam logic [CAUSE_W-1:0] ECALL_BASE = 4'd8;

  localparam logic [CSR_AW-1:0] A_STATUS  = 4'd0;
  localparam logic [CSR_AW-1:0] A_IE      = 4'd1;
  localparam logic [CSR_AW-1:0] A_MVEC    = 4'd2;
  localparam logic [CSR_AW-1:0] A_EDELEG  = 4'd3;
  localparam logic [CSR_AW-1:0] A_IDELEG  = 4'd4;
  localparam logic [CSR_AW-1:0] A_MEPC    = 4'd5;
  localparam logic [CSR_AW-1:0] A_MCAUSE  = 4'd6;
  localparam logic [CSR_AW-1:0] A_MTVAL   = 4'd7;
  localparam logic [CSR_AW-1:0] A_SVEC    = 4'd8;
  localparam logic [CSR_AW-1:0] A_SEPC    = 4'd9;
  localparam logic [CSR_AW-1:0] A_SCAUSE  = 4'd10;
  localparam logic [CSR_AW-1:0] A_STVAL   = 4'd11;

  typedef struct packed {
    logic               takeTrap;
    logic               toSup;
    logic               isIrq;
    logic [CAUSE_W-1:0] code;
    logic               doMret;
    logic               doSret;
  } trap_strobe_t;
endpackage

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
  import mtrap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 excValid,
  input  logic                 excEcall,
  input  logic [CAUSE_W-1:0]   excCode,
  input  logic [NUM_IRQ-1:0]   irqLine,
  input  logic                 mretValid,
  input  logic                 sretValid,
  input  logic [1:0]           priv,
  input  logic                 mie,
  input  logic                 sie,
  input  logic [NUM_IRQ-1:0]   irqEn,
  input  logic [NUM_IRQ-1:0]   irqDeleg,
  input  logic [NUM_CODES-1:0] excDelegMask,
  output trap_strobe_t         stb
);
  logic [NUM_IRQ-1:0] irqToSup;
  logic [NUM_IRQ-1:0] takeable;
  logic [NUM_IRQ-1:0] grant;
  logic [CAUSE_W-1:0] irqCode;
  logic [CAUSE_W-1:0] excCodeEff;
  logic               excToSup;
  logic               anyIrq;

  // per-source routing and gating
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irqToSup[i] = irqDeleg[i] && (priv != PRIV_M);
    assign takeable[i] = irqLine[i] && irqEn[i] &&
                         (irqToSup[i] ? ((priv == PRIV_U) || ((priv == PRIV_S) && sie))
                                      : ((priv != PRIV_M) || mie));
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    grant = '0;
    irqCode = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      grant[i] = takeable[i] & ~seen;
      seen = seen | takeable[i];
      if (grant[i]) irqCode = IRQ_CODE[i];
    end
  end

  assign anyIrq = |takeable;
  assign excCodeEff = excEcall ? (ECALL_BASE + {2'b00, priv}) : excCode;
  assign excToSup = excDelegMask[excCodeEff] && (priv != PRIV_M);

  always_comb begin
    stb.takeTrap = excValid | anyIrq;
    stb.isIrq    = ~excValid & anyIrq;
    stb.code     = excValid ? excCodeEff : irqCode;
    stb.toSup    = excValid ? excToSup : |(grant & irqToSup);
    stb.doMret   = mretValid & ~stb.takeTrap;
    stb.doSret   = sretValid & ~mretValid & ~stb.takeTrap;
  end

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  p_exc_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (stb.takeTrap && !stb.isIrq));
  p_stay_machine_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeTrap && priv == PRIV_M) |-> !stb.toSup);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.isIrq && priv == PRIV_M) |-> mie);
endmodule

// File: rtl/mtrap_regs.sv
module mtrap_regs
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trap_strobe_t         stb,
  input  logic [XLEN-1:0]      excTval,
  input  logic [XLEN-1:0]      curPc,
  input  logic                 csrWe,
  input  logic [CSR_AW-1:0]    csrAddr,
  input  logic [XLEN-1:0]      csrWdata,
  output logic [XLEN-1:0]      csrRdata,
  output logic                 redirectValid,
  output logic [XLEN-1:0]      redirectPc,
  output logic [1:0]           privQ,
  output logic                 mieQ,
  output logic                 sieQ,
  output logic [NUM_IRQ-1:0]   irqEn,
  output logic [NUM_IRQ-1:0]   irqDeleg,
  output logic [NUM_CODES-1:0] edelegQ
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic                 mpieQ, spieQ, sppQ;
  logic [1:0]           mppQ;
  logic [NUM_CODES-1:0] ieQ, idelegQ;
  logic [XLEN-1:0]      mvecQ, svecQ, mepcQ, sepcQ, mcauseQ, scauseQ, mtvalQ, stvalQ;
  logic [XLEN-1:0]      statusWord, causeWord, tvalWord, vecSel, vecBase, trapPc;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_gather
    assign irqEn[i]    = ieQ[IRQ_CODE[i]];
    assign irqDeleg[i] = idelegQ[IRQ_CODE[i]];
  end

  assign statusWord = XLEN'({mppQ, 2'b00, sppQ, mpieQ, 1'b0, spieQ, 1'b0, mieQ, 1'b0, sieQ, 1'b0});
  assign causeWord  = {stb.isIrq, {PAD_W{1'b0}}, stb.code};
  assign tvalWord   = stb.isIrq ? '0 : excTval;

  always_comb begin
    vecSel  = stb.toSup ? svecQ : mvecQ;
    vecBase = {vecSel[XLEN-1:2], 2'b00};
    if (stb.isIrq && vecSel[1:0] == 2'b01)
      trapPc = vecBase + ({{(XLEN-CAUSE_W){1'b0}}, stb.code} << 2);
    else
      trapPc = vecBase;
  end

  assign redirectValid = stb.takeTrap | stb.doMret | stb.doSret;
  assign redirectPc    = stb.takeTrap ? trapPc : (stb.doMret ? mepcQ : sepcQ);

  always_comb begin
    case (csrAddr)
      A_STATUS: csrRdata = statusWord;
      A_IE:     csrRdata = XLEN'(ieQ);
      A_MVEC:   csrRdata = mvecQ;
      A_EDELEG: csrRdata = XLEN'(edelegQ);
      A_IDELEG: csrRdata = XLEN'(idelegQ);
      A_MEPC:   csrRdata = mepcQ;
      A_MCAUSE: csrRdata = mcauseQ;
      A_MTVAL:  csrRdata = mtvalQ;
      A_SVEC:   csrRdata = svecQ;
      A_SEPC:   csrRdata = sepcQ;
      A_SCAUSE: csrRdata = scauseQ;
      A_STVAL:  csrRdata = stvalQ;
      default:  csrRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      privQ <= PRIV_M;
      {mieQ, sieQ, mpieQ, spieQ, sppQ} <= '0;
      mppQ <= PRIV_U;
      {ieQ, idelegQ, edelegQ} <= '0;
      {mvecQ, svecQ, mepcQ, sepcQ} <= '0;
      {mcauseQ, scauseQ, mtvalQ, stvalQ} <= '0;
    end else if (stb.takeTrap && stb.toSup) begin
      sepcQ <= curPc;  scauseQ <= causeWord;  stvalQ <= tvalWord;
      spieQ <= sieQ;   sieQ <= 1'b0;          sppQ <= privQ[0];
      privQ <= PRIV_S;
    end else if (stb.takeTrap) begin
      mepcQ <= curPc;  mcauseQ <= causeWord;  mtvalQ <= tvalWord;
      mpieQ <= mieQ;   mieQ <= 1'b0;          mppQ <= privQ;
      privQ <= PRIV_M;
    end else if (stb.doMret) begin
      privQ <= mppQ;   mieQ <= mpieQ;  mpieQ <= 1'b1;  mppQ <= PRIV_U;
    end else if (stb.doSret) begin
      privQ <= {1'b0, sppQ};  sieQ <= spieQ;  spieQ <= 1'b1;  sppQ <= 1'b0;
    end else if (csrWe) begin
      case (csrAddr)
        A_STATUS: begin
          sieQ  <= csrWdata[1];  mieQ  <= csrWdata[3];
          spieQ <= csrWdata[5];  mpieQ <= csrWdata[7];
          sppQ  <= csrWdata[8];
          mppQ  <= (csrWdata[12:11] == 2'b10) ? PRIV_U : csrWdata[12:11];
        end
        A_IE:     ieQ     <= csrWdata[NUM_CODES-1:0];
        A_MVEC:   mvecQ   <= csrWdata;
        A_EDELEG: edelegQ <= csrWdata[NUM_CODES-1:0];
        A_IDELEG: idelegQ <= csrWdata[NUM_CODES-1:0];
        A_MEPC:   mepcQ   <= csrWdata;
        A_MCAUSE: mcauseQ <= csrWdata;
        A_MTVAL:  mtvalQ  <= csrWdata;
        A_SVEC:   svecQ   <= csrWdata;
        A_SEPC:   sepcQ   <= csrWdata;
        A_SCAUSE: scauseQ <= csrWdata;
        A_STVAL:  stvalQ  <= csrWdata;
        default: ;
      endcase
    end
  end

  p_no_demote_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeTrap |=> (privQ >= $past(privQ)));
  p_mie_cleared_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeTrap && !stb.toSup) |=> (!mieQ && privQ == PRIV_M));
  p_sie_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeTrap && stb.toSup) |=> (!sieQ && privQ == PRIV_S));
  p_mret_stack_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.doMret |=> (mpieQ && mppQ == PRIV_U));
  p_sret_stack_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.doSret |=> (spieQ && !sppQ && privQ != PRIV_M));
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                excValid,
  input  logic                excEcall,
  input  logic [CAUSE_W-1:0]  excCode,
  input  logic [XLEN-1:0]     excTval,
  input  logic [XLEN-1:0]     curPc,
  input  logic                irqSoft,
  input  logic                irqTimer,
  input  logic                irqExt,
  input  logic                mretValid,
  input  logic                sretValid,
  input  logic                csrWe,
  input  logic [CSR_AW-1:0]   csrAddr,
  input  logic [XLEN-1:0]     csrWdata,
  output logic [XLEN-1:0]     csrRdata,
  output logic                redirectValid,
  output logic [XLEN-1:0]     redirectPc,
  output logic [1:0]          privMode
);
  trap_strobe_t         stb;
  logic                 mie, sie;
  logic [NUM_IRQ-1:0]   irqEn, irqDeleg;
  logic [NUM_CODES-1:0] edeleg;

  mtrap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .excValid(excValid), .excEcall(excEcall), .excCode(excCode),
    .irqLine({irqTimer, irqSoft, irqExt}),
    .mretValid(mretValid), .sretValid(sretValid),
    .priv(privMode), .mie(mie), .sie(sie),
    .irqEn(irqEn), .irqDeleg(irqDeleg), .excDelegMask(edeleg),
    .stb(stb)
  );

  mtrap_regs #(.XLEN(XLEN)) i_regs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .excTval(excTval), .curPc(curPc),
    .csrWe(csrWe), .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .privQ(privMode), .mieQ(mie), .sieQ(sie),
    .irqEn(irqEn), .irqDeleg(irqDeleg), .edelegQ(edeleg)
  );
endmodule

// File: tb/test_mtrap_unit.sv
`timescale 1ns/1ps
module test_mtrap_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 0, excEcall = 0, irqSoft = 0, irqTimer = 0, irqExt = 0;
  logic        mretValid = 0, sretValid = 0, csrWe = 0;
  logic [3:0]  excCode = '0, csrAddr = '0;
  logic [31:0] excTval = '0, curPc = '0, csrWdata = '0;
  logic [31:0] csrRdata, redirectPc;
  logic        redirectValid;
  logic [1:0]  privMode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {logic v; logic [31:0] pc; logic [7:0] req;} exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  mtrap_unit i_mtrap_unit (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excEcall(excEcall), .excCode(excCode),
    .excTval(excTval), .curPc(curPc), .irqSoft(irqSoft), .irqTimer(irqTimer), .irqExt(irqExt),
    .mretValid(mretValid), .sretValid(sretValid), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .privMode(privMode)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected redirect items and compares mid-cycle
  initial forever begin
    @(negedge clk);
    #5;
    if (expQ.size() > 0) begin
      exp_t it;
      it = expQ.pop_front();
      chk(int'(it.req), {31'd0, redirectValid}, {31'd0, it.v});
      if (it.v) chk(int'(it.req), redirectPc, it.pc);
    end
  end

  // driver: one stimulus cycle plus its expected redirect
  task automatic drive(input logic ev, input logic ec, input logic [3:0] code,
                       input logic [31:0] tv, input logic [31:0] pc, input logic [2:0] irq,
                       input logic mr, input logic sr, input logic expV,
                       input logic [31:0] expPc, input int req);
    @(negedge clk);
    excValid = ev; excEcall = ec; excCode = code; excTval = tv; curPc = pc;
    {irqExt, irqSoft, irqTimer} = irq; mretValid = mr; sretValid = sr;
    expQ.push_back('{expV, expPc, 8'(req)});
    @(negedge clk);
    excValid = 0; excEcall = 0; excCode = '0; excTval = '0;
    {irqExt, irqSoft, irqTimer} = '0; mretValid = 0; sretValid = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    csrWe = 1; csrAddr = a; csrWdata = d;
    @(negedge clk);
    csrWe = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] mask, input logic [31:0] exp, input int req);
    @(negedge clk);
    csrAddr = a;
    #2;
    chk(req, csrRdata & mask, exp);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #2;
    chk(1, privMode, 3);
    chk(1, redirectValid, 0);
    rd(0, 32'hFFFF_FFFF, 0, 1);
    rd(6, 32'hFFFF_FFFF, 0, 1);
    rd(10, 32'hFFFF_FFFF, 0, 1);

    wr(2, 32'h100);
    // R2 plain exception from machine mode
    drive(1, 0, 4'd2, 32'hDEAD, 32'h40, 3'b000, 0, 0, 1, 32'h100, 2);
    chk(2, privMode, 3);
    rd(5, 32'hFFFF_FFFF, 32'h40, 2);
    rd(6, 32'hFFFF_FFFF, 32'h2, 2);
    rd(7, 32'hFFFF_FFFF, 32'hDEAD, 2);
    rd(0, 32'hFFFF_FFFF, 32'h1800, 3);   // R3 mpp=M, mpie=0
    // R4 returns: first to machine, then to user
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h40, 4);
    chk(4, privMode, 3);
    rd(0, 32'hFFFF_FFFF, 32'h80, 4);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h40, 4);
    chk(4, privMode, 0);
    rd(0, 32'hFFFF_FFFF, 32'h88, 4);
    // R11 environment call from user
    drive(1, 1, 4'd5, 0, 32'h200, 3'b000, 0, 0, 1, 32'h100, 11);
    chk(11, privMode, 3);
    rd(6, 32'hFFFF_FFFF, 32'h8, 11);
    rd(0, 32'hFFFF_FFFF, 32'h80, 3);     // R3 mpie took mie=1
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h200, 4);
    chk(4, privMode, 0);

    // R5 vectored mode
    wr(2, 32'h101);
    wr(1, 32'h888);
    drive(0, 0, 0, 0, 32'h210, 3'b001, 0, 0, 1, 32'h11C, 5);
    rd(6, 32'hFFFF_FFFF, 32'h8000_0007, 9);   // R9 cause MSB
    rd(7, 32'hFFFF_FFFF, 32'h0, 9);
    rd(5, 32'hFFFF_FFFF, 32'h210, 5);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h210, 4);
    drive(1, 0, 4'd5, 32'h1, 32'h214, 3'b000, 0, 0, 1, 32'h100, 5);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h214, 4);
    // R9 priority
    drive(0, 0, 0, 0, 32'h218, 3'b111, 0, 0, 1, 32'h12C, 9);
    rd(6, 32'hFFFF_FFFF, 32'h8000_000B, 9);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h218, 4);
    drive(0, 0, 0, 0, 32'h21C, 3'b011, 0, 0, 1, 32'h10C, 9);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h21C, 4);
    // R10 exception beats interrupt
    drive(1, 0, 4'd4, 32'h55, 32'h220, 3'b100, 0, 0, 1, 32'h100, 10);
    rd(6, 32'hFFFF_FFFF, 32'h4, 10);
    rd(7, 32'hFFFF_FFFF, 32'h55, 10);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h220, 4);

    // R8 gating
    drive(1, 1, 0, 0, 32'h224, 3'b000, 0, 0, 1, 32'h100, 11);
    drive(0, 0, 0, 0, 32'h228, 3'b100, 0, 0, 0, 32'h0, 8);   // machine, mie=0
    chk(8, privMode, 3);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h224, 4);
    chk(8, privMode, 0);
    wr(1, 32'h080);
    drive(0, 0, 0, 0, 32'h22C, 3'b010, 0, 0, 0, 32'h0, 8);   // soft enable clear
    chk(8, privMode, 0);
    wr(0, 32'h80);                                           // user, mie=0
    drive(0, 0, 0, 0, 32'h230, 3'b001, 0, 0, 1, 32'h11C, 8);
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h230, 4);
    chk(4, privMode, 0);
    wr(1, 32'h888);

    // R6 delegation
    wr(3, 32'h100);
    wr(4, 32'h80);
    wr(8, 32'h300);
    drive(1, 1, 0, 0, 32'h400, 3'b000, 0, 0, 1, 32'h300, 6);
    chk(6, privMode, 1);
    rd(10, 32'hFFFF_FFFF, 32'h8, 6);
    rd(9, 32'hFFFF_FFFF, 32'h400, 6);
    rd(6, 32'hFFFF_FFFF, 32'h8000_0007, 6);                 // machine cause untouched
    drive(0, 0, 0, 0, 32'h404, 3'b001, 0, 0, 0, 32'h0, 8);  // delegated timer, sie=0
    chk(8, privMode, 1);
    drive(0, 0, 0, 0, 32'h500, 3'b100, 0, 0, 1, 32'h12C, 6);
    chk(6, privMode, 3);
    rd(0, 32'h1800, 32'h0800, 3);                            // R3 mpp=S
    drive(0, 0, 0, 0, 0, 3'b000, 1, 0, 1, 32'h500, 4);
    chk(4, privMode, 1);
    drive(0, 0, 0, 0, 0, 3'b000, 0, 1, 1, 32'h400, 4);
    chk(4, privMode, 0);
    rd(0, 32'h0122, 32'h0020, 4);                            // spie=1, sie=0, spp=U

    // R11 supervisor and machine call codes, R7 machine keeps traps
    drive(1, 1, 0, 0, 32'h600, 3'b000, 0, 0, 1, 32'h300, 6);
    drive(1, 1, 0, 0, 32'h604, 3'b000, 0, 0, 1, 32'h100, 11);
    rd(6, 32'hFFFF_FFFF, 32'h9, 11);
    chk(11, privMode, 3);
    drive(1, 0, 4'd8, 0, 32'h608, 3'b000, 0, 0, 1, 32'h100, 7);
    chk(7, privMode, 3);
    rd(9, 32'hFFFF_FFFF, 32'h600, 7);
    rd(6, 32'hFFFF_FFFF, 32'h8, 7);
    drive(1, 1, 0, 0, 32'h60C, 3'b000, 0, 0, 1, 32'h100, 11);
    rd(6, 32'hFFFF_FFFF, 32'hB, 11);

    // R12 register port
    rd(2, 32'hFFFF_FFFF, 32'h101, 12);
    rd(15, 32'hFFFF_FFFF, 32'h0, 12);
    rd(4, 32'hFFFF_FFFF, 32'h80, 12);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule